// File: doc/BRIEF.md
# Accumulator ALU with Shifted Store Path

This block is the arithmetic heart of a fixed-point datapath. It holds a 32-bit accumulator that is the first operand of every operation. The second operand is picked per operation, either from the multiplier's product input or from the already-scaled data input. Load, add, subtract, AND, OR, XOR and a normalize step all finish in a single clock and write their result back into the accumulator. Zero and negative flags follow the accumulator, and a sticky-until-next-operation overflow flag reports signed add and subtract overflow.

Support paths run beside the ALU. A normalize step lets an outside sequencer scale a fixed-point value until its top two bits differ while counting the shifts. A bit-test port picks one bit of a 16-bit data word for a conditional branch. The low half of the accumulator is offered as a branch target. A store path shifts the accumulator left by 0 to 7 places and hands out either 16-bit half without disturbing the accumulator.

Top module: `acc_alu_unit`

## Requirements
- R1: After reset the accumulator is 0, the overflow flag is 0 and the zero flag is 1.
- R2: The second operand is the product input when src_sel_i is 0 and the scaled data input when it is 1; LOAD (opcode 1) copies that operand into the accumulator on the next clock.
- R3: ADD (opcode 2) writes accumulator plus operand and SUB (opcode 3) writes accumulator minus operand, both modulo 2^32.
- R4: AND (opcode 4), OR (opcode 5) and XOR (opcode 6) write the bitwise result of accumulator and operand.
- R5: With op_valid_i low, or with NOP (opcode 0), the accumulator keeps its value.
- R6: The overflow flag is set by an ADD or SUB whose signed result overflows, cleared by any other valid non-NOP operation, and held by NOP or idle cycles.
- R7: zero_o is 1 exactly when the accumulator is 0 and neg_o equals accumulator bit 31.
- R8: NORM (opcode 7) with accumulator bits 31 and 30 equal shifts the accumulator left by one (zero filled) and raises norm_inc_o in the cycle of the operation.
- R9: NORM with bits 31 and 30 different raises norm_done_o, keeps norm_inc_o low and leaves the accumulator unchanged.
- R10: test_bit_o equals bit test_idx_i of test_word_i, index 15 being the most significant bit.
- R11: branch_addr_o equals the low 16 bits of the accumulator.
- R12: store_data_o is bits 31..16 (store_hi_i = 1) or bits 15..0 (store_hi_i = 0) of the accumulator shifted left by store_shift_i (0 to 7, zero filled), and using it never changes the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| src_sel_i | input | 1 | Operand select: 0 product, 1 scaled data |
| prod_i | input | 32 | Product register value |
| scaled_i | input | 32 | Scaled data value |
| acc_o | output | 32 | Accumulator |
| zero_o | output | 1 | Accumulator is zero |
| neg_o | output | 1 | Accumulator sign |
| ovf_o | output | 1 | Signed overflow of last ALU operation |
| norm_inc_o | output | 1 | Normalize shift taken, increment count |
| norm_done_o | output | 1 | Normalize finished |
| test_word_i | input | 16 | Word for bit test |
| test_idx_i | input | 4 | Bit index to test |
| test_bit_o | output | 1 | Selected bit |
| branch_addr_o | output | 16 | Branch target from accumulator |
| store_hi_i | input | 1 | Store half select: 1 high, 0 low |
| store_shift_i | input | 3 | Store left shift amount |
| store_data_o | output | 16 | Shifted half for storage |

## Verification
Every cycle the assertions guard that the accumulator is frozen on idle and NOP cycles, that a load takes the selected operand, that a normalize either doubles the accumulator or leaves it alone with exactly one of its two strobes raised, and that logic operations never leave overflow set. Arithmetic values, the overflow boundaries at the signed extremes, the full normalize run length from a small value, the bit-test index ordering and the exact halves produced by each store shift can only be shown by the bench's directed scenarios against its own model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_NORM = 3'd7
  } alu_op_e;
endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              valid_i,
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              ovf_wr_o,
  output logic              ovf_next_o,
  output logic              norm_inc_o,
  output logic              norm_done_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, diff;
  logic              norm_eq;

  assign sum     = acc_i + opnd_i;
  assign diff    = acc_i - opnd_i;
  assign norm_eq = (acc_i[MSB] == acc_i[MSB-1]);

  always_comb begin
    result_o    = acc_i;
    wr_en_o     = 1'b0;
    ovf_wr_o    = 1'b0;
    ovf_next_o  = 1'b0;
    norm_inc_o  = 1'b0;
    norm_done_o = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        OP_NOP: ;
        OP_LOAD: begin result_o = opnd_i; wr_en_o = 1'b1; ovf_wr_o = 1'b1; end
        OP_ADD: begin
          result_o   = sum;
          wr_en_o    = 1'b1;
          ovf_wr_o   = 1'b1;
          ovf_next_o = (acc_i[MSB] == opnd_i[MSB]) && (sum[MSB] != acc_i[MSB]);
        end
        OP_SUB: begin
          result_o   = diff;
          wr_en_o    = 1'b1;
          ovf_wr_o   = 1'b1;
          ovf_next_o = (acc_i[MSB] != opnd_i[MSB]) && (diff[MSB] != acc_i[MSB]);
        end
        OP_AND: begin result_o = acc_i & opnd_i; wr_en_o = 1'b1; ovf_wr_o = 1'b1; end
        OP_OR:  begin result_o = acc_i | opnd_i; wr_en_o = 1'b1; ovf_wr_o = 1'b1; end
        OP_XOR: begin result_o = acc_i ^ opnd_i; wr_en_o = 1'b1; ovf_wr_o = 1'b1; end
        OP_NORM: begin
          ovf_wr_o = 1'b1;
          if (norm_eq) begin
            result_o   = {acc_i[MSB-1:0], 1'b0};
            wr_en_o    = 1'b1;
            norm_inc_o = 1'b1;
          end else begin
            norm_done_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    AST_NORM_EXCL: assert (!(norm_inc_o && norm_done_o)); // R9
  end
endmodule

// File: rtl/acc_store_shift.sv
module acc_store_shift #(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = 3
) (
  input  logic [DATA_W-1:0]   acc_i,
  input  logic                hi_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic [DATA_W/2-1:0] data_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] shifted;
  assign shifted = acc_i << shift_i;
  assign data_o  = hi_i ? shifted[DATA_W-1:HALF_W] : shifted[HALF_W-1:0];
endmodule

// File: rtl/acc_bit_test.sv
module acc_bit_test #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] onehot;
  for (genvar g = 0; g < WORD_W; g++) begin : g_sel
    assign onehot[g] = (idx_i == IDX_W'(g)) & word_i[g];
  end
  assign bit_o = |onehot;
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = 3,
  parameter int HALF_W  = DATA_W / 2,
  parameter int IDX_W   = $clog2(HALF_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [2:0]         op_i,
  input  logic               src_sel_i,
  input  logic [DATA_W-1:0]  prod_i,
  input  logic [DATA_W-1:0]  scaled_i,
  output logic [DATA_W-1:0]  acc_o,
  output logic               zero_o,
  output logic               neg_o,
  output logic               ovf_o,
  output logic               norm_inc_o,
  output logic               norm_done_o,
  input  logic [HALF_W-1:0]  test_word_i,
  input  logic [IDX_W-1:0]   test_idx_i,
  output logic               test_bit_o,
  output logic [HALF_W-1:0]  branch_addr_o,
  input  logic               store_hi_i,
  input  logic [SHIFT_W-1:0] store_shift_i,
  output logic [HALF_W-1:0]  store_data_o
);
  logic [DATA_W-1:0] acc_q, opnd, result;
  logic              ovf_q, wr_en, ovf_wr, ovf_next;
  alu_op_e           op;

  assign op   = alu_op_e'(op_i);
  assign opnd = src_sel_i ? scaled_i : prod_i;

  acc_alu_core #(.DATA_W(DATA_W)) u_core (
    .valid_i    (op_valid_i),
    .op_i       (op),
    .acc_i      (acc_q),
    .opnd_i     (opnd),
    .result_o   (result),
    .wr_en_o    (wr_en),
    .ovf_wr_o   (ovf_wr),
    .ovf_next_o (ovf_next),
    .norm_inc_o (norm_inc_o),
    .norm_done_o(norm_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_en)  acc_q <= result;
      if (ovf_wr) ovf_q <= ovf_next;
    end
  end

  assign acc_o         = acc_q;
  assign zero_o        = (acc_q == '0);
  assign neg_o         = acc_q[DATA_W-1];
  assign ovf_o         = ovf_q;
  assign branch_addr_o = acc_q[HALF_W-1:0];

  acc_store_shift #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_store (
    .acc_i  (acc_q),
    .hi_i   (store_hi_i),
    .shift_i(store_shift_i),
    .data_o (store_data_o)
  );

  acc_bit_test #(.WORD_W(HALF_W), .IDX_W(IDX_W)) u_btest (
    .word_i(test_word_i),
    .idx_i (test_idx_i),
    .bit_o (test_bit_o)
  );

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i || op == OP_NOP) |=> $stable(acc_o)); // R5
  AST_LOAD_OPND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_LOAD) |=> acc_o == $past(opnd)); // R2
  AST_NORM_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_NORM && norm_inc_o) |=> acc_o == ($past(acc_o) << 1)); // R8
  AST_NORM_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_NORM && norm_done_o) |=> $stable(acc_o)); // R9
  AST_NO_OVF_LOGIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !ovf_o); // R6
endmodule

// File: tb/sim_acc_alu_unit.sv
module sim_acc_alu_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        src_sel = 1'b0;
  logic [31:0] prod = '0, scaled = '0;
  logic [31:0] acc;
  logic        zero, neg, ovf, n_inc, n_done;
  logic [15:0] t_word = '0;
  logic [3:0]  t_idx = '0;
  logic        t_bit;
  logic [15:0] br_addr;
  logic        st_hi = 1'b0;
  logic [2:0]  st_sh = '0;
  logic [15:0] st_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_acc;
  logic        m_ovf;

  always #4 clk = ~clk;

  acc_alu_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .src_sel_i(src_sel),
    .prod_i(prod), .scaled_i(scaled), .acc_o(acc), .zero_o(zero), .neg_o(neg), .ovf_o(ovf),
    .norm_inc_o(n_inc), .norm_done_o(n_done), .test_word_i(t_word), .test_idx_i(t_idx),
    .test_bit_o(t_bit), .branch_addr_o(br_addr), .store_hi_i(st_hi), .store_shift_i(st_sh),
    .store_data_o(st_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one op at negedge, check accumulator at the following negedge
  task automatic run_op(logic [2:0] o, logic sel, logic [31:0] v);
    @(negedge clk);
    op = o; src_sel = sel; op_valid = 1'b1;
    if (sel) begin scaled = v; prod = ~v; end else begin prod = v; scaled = ~v; end
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check_flags(string req);
    chk({req, "/R7 zero"}, 32'(zero), 32'(m_acc == 0));
    chk({req, "/R7 neg"},  32'(neg),  32'(m_acc[31]));
  endtask

  task automatic t_reset;
    chk("R1 acc", acc, 0);
    chk("R1 ovf", 32'(ovf), 0);
    chk("R1 zero", 32'(zero), 1);
  endtask

  task automatic t_load;
    run_op(3'd1, 1'b0, 32'h1234_5678); m_acc = 32'h1234_5678;
    chk("R2 load product", acc, m_acc);
    run_op(3'd1, 1'b1, 32'hCAFE_0001); m_acc = 32'hCAFE_0001;
    chk("R2 load scaled", acc, m_acc);
    check_flags("R2");
    chk("R11 branch", 32'(br_addr), 32'h0001);
  endtask

  task automatic t_arith;
    run_op(3'd1, 1'b0, 32'h7FFF_FFFF);
    run_op(3'd2, 1'b1, 32'h0000_0001); m_acc = 32'h8000_0000;
    chk("R3 add", acc, m_acc);
    chk("R6 add ovf", 32'(ovf), 1);
    check_flags("R3");
    run_op(3'd0, 1'b0, 32'h5);
    chk("R6 nop holds ovf", 32'(ovf), 1);
    chk("R5 nop holds acc", acc, m_acc);
    run_op(3'd3, 1'b0, 32'h0000_0001); m_acc = 32'h7FFF_FFFF;
    chk("R3 sub", acc, m_acc);
    chk("R6 sub ovf", 32'(ovf), 1);
    run_op(3'd3, 1'b0, 32'h7FFF_FFFF); m_acc = 0;
    chk("R3 sub to zero", acc, 0);
    chk("R6 no ovf", 32'(ovf), 0);
    check_flags("R3 zero");
    run_op(3'd3, 1'b1, 32'h0000_0003); m_acc = 32'hFFFF_FFFD;
    chk("R3 sub negative", acc, m_acc);
    check_flags("R3 neg");
  endtask

  task automatic t_logic;
    run_op(3'd1, 1'b0, 32'hF0F0_AAAA);
    run_op(3'd2, 1'b0, 32'h8000_0000);   // overflow -> set
    chk("R6 set before logic", 32'(ovf), 1);
    m_acc = 32'h70F0_AAAA;
    run_op(3'd4, 1'b1, 32'h0FF0_FF00); m_acc = m_acc & 32'h0FF0_FF00;
    chk("R4 and", acc, m_acc);
    chk("R6 logic clears", 32'(ovf), 0);
    run_op(3'd5, 1'b0, 32'h1200_0034); m_acc = m_acc | 32'h1200_0034;
    chk("R4 or", acc, m_acc);
    run_op(3'd6, 1'b1, 32'hFFFF_0000); m_acc = m_acc ^ 32'hFFFF_0000;
    chk("R4 xor", acc, m_acc);
  endtask

  task automatic t_idle;
    @(negedge clk);
    op = 3'd1; prod = 32'hDEAD_BEEF; scaled = 32'hDEAD_BEEF; op_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 idle ignores load", acc, m_acc);
  endtask

  task automatic t_norm;
    int steps = 0;
    run_op(3'd1, 1'b0, 32'h0000_1000); m_acc = 32'h0000_1000;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      op = 3'd7; op_valid = 1'b1;
      #1;
      if (m_acc[31] == m_acc[30]) begin
        chk("R8 inc", 32'(n_inc), 1);
        chk("R8 done low", 32'(n_done), 0);
        steps++;
        m_acc = m_acc << 1;
        @(negedge clk); op_valid = 1'b0;
        chk("R8 shifted", acc, m_acc);
      end else begin
        chk("R9 done", 32'(n_done), 1);
        chk("R9 inc low", 32'(n_inc), 0);
        @(negedge clk); op_valid = 1'b0;
        chk("R9 unchanged", acc, m_acc);
        break;
      end
    end
    chk("R8 step count", 32'(steps), 18);
    chk("R8 final", acc, 32'h4000_0000);
  endtask

  task automatic t_bittest;
    @(negedge clk);
    t_word = 16'h8001;
    t_idx = 4'd15; #1; chk("R10 msb", 32'(t_bit), 1);
    t_idx = 4'd0;  #1; chk("R10 lsb", 32'(t_bit), 1);
    t_idx = 4'd7;  #1; chk("R10 zero bit", 32'(t_bit), 0);
    t_word = 16'h0400; t_idx = 4'd10; #1; chk("R10 bit10", 32'(t_bit), 1);
  endtask

  task automatic t_store;
    run_op(3'd1, 1'b0, 32'h8123_4567); m_acc = 32'h8123_4567;
    st_hi = 1'b1; st_sh = 3'd0; #1; chk("R12 hi sh0", 32'(st_data), 32'h8123);
    st_hi = 1'b0; #1; chk("R12 lo sh0", 32'(st_data), 32'h4567);
    st_sh = 3'd4; #1; chk("R12 lo sh4", 32'(st_data), 32'h5670);
    st_hi = 1'b1; #1; chk("R12 hi sh4", 32'(st_data), 32'h1234);
    st_sh = 3'd7; #1; chk("R12 hi sh7", 32'(st_data), 32'h91A2);
    @(negedge clk); @(negedge clk);
    chk("R12 acc intact", acc, m_acc);
    chk("R11 branch", 32'(br_addr), 32'h4567);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_acc = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_load();
    t_arith();
    t_logic();
    t_idle();
    t_norm();
    t_bittest();
    t_store();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule